// File: doc/BRIEF.md
# Force/Measure Unit Digital Control Front End

This block is the clocked control logic in front of one force/measure channel of a tester pin. A host drives an active-low select and an active-low strobe. On a strobe rising edge seen while the select is low, the block captures a set of configuration levels: a three-bit current-range code, a two-bit compensation-capacitor code, force-mode, measure-source and compare-source selects, and a standby request. From the captured configuration it drives one-hot range enables, two relay enables for the externally buffered ranges, an effective standby indication and a one-hot capacitor enable.

A digital window comparator checks a signed voltage code or current code against an upper and a lower threshold code. The comparison is sampled on a rising edge of a separate compare clock and held as a pending result. The two result flags reach the outputs only at the next qualifying strobe rising edge. Two clamp-detect inputs are likewise republished as registered flags on each qualifying strobe. A multiplexed measurement output carries either the voltage or the current code and floats when its active-low output enable is high.

All control inputs are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges are detected after it. The measurement and threshold codes are treated as level samples already in the clock domain. They carry no handshake because the comparator samples them only on compare-clock edges.

Top module: `pmu_ctrl_if`

## Requirements
- R1: A strobe rising edge while the select input is high changes no output and captures no configuration.
- R2: Range codes 000, 001, 010 and 011 (bit 0 is the least significant mode bit) drive exactly bit 0, 1, 2 or 3 of `range_en`; every other code leaves `range_en` all zero.
- R3: `ext4_en` is high only for range code 100 and `ext5_en` is high only for range code 101.
- R4: `standby_out` is high when the captured standby request is high or the captured range code is 110 or 111.
- R5: `cap_en` is one-hot: code 00 gives bit 0, code 01 gives bit 1, code 10 gives bit 2.
- R6: Capacitor code 11 selects bit 0 of `cap_en` and sets `cfg_illegal`, which stays high until reset.
- R7: On a compare-clock rising edge the comparator samples the voltage code when the captured compare select is 0 and the current code when it is 1.
- R8: `cmp_hi` (sample strictly above the upper threshold) and `cmp_lo` (sample strictly below the lower threshold) change only at a qualifying strobe rising edge, and then show the most recent compare-clock sample.
- R9: `meas_out` carries the voltage code when the captured measure select is 0 and the current code when it is 1; it is high impedance while `meas_oe_n` is high.
- R10: `clamp_hi_flag` and `clamp_lo_flag` take the clamp-detect input levels at each qualifying strobe rising edge and hold between strobes.
- R11: After reset: standby high, range 0 enabled, capacitor 0 enabled, comparator and clamp flags low, `cfg_illegal` low.
- R12: `force_current` follows the captured force-mode select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low unit select (asynchronous) |
| stb_n | input | 1 | Active-low strobe; rising edge captures (asynchronous) |
| cmp_clk | input | 1 | Compare clock; rising edge samples comparator (asynchronous) |
| range_code | input | 3 | Current-range code |
| cap_code | input | 2 | Compensation-capacitor code |
| force_sel | input | 1 | 0 force voltage, 1 force current |
| meas_sel | input | 1 | 0 voltage, 1 current on `meas_out` |
| cmp_sel | input | 1 | 0 voltage, 1 current to comparator |
| standby_req | input | 1 | Standby request |
| clamp_hi_det | input | 1 | Upper clamp active indication |
| clamp_lo_det | input | 1 | Lower clamp active indication |
| meas_oe_n | input | 1 | Active-low enable of `meas_out` |
| v_code | input | MEAS_W | Signed voltage measurement code |
| i_code | input | MEAS_W | Signed current measurement code |
| thr_hi | input | MEAS_W | Signed upper threshold |
| thr_lo | input | MEAS_W | Signed lower threshold |
| range_en | output | 4 | One-hot internal range enables |
| ext4_en | output | 1 | External range 4 relay enable |
| ext5_en | output | 1 | External range 5 relay enable |
| standby_out | output | 1 | Effective standby |
| cap_en | output | 3 | One-hot compensation-capacitor enable |
| force_current | output | 1 | Captured force-mode select |
| meas_out | output | MEAS_W | Multiplexed measurement, tri-state |
| cmp_hi | output | 1 | Published above-window flag |
| cmp_lo | output | 1 | Published below-window flag |
| clamp_hi_flag | output | 1 | Registered upper clamp flag |
| clamp_lo_flag | output | 1 | Registered lower clamp flag |
| cfg_illegal | output | 1 | Sticky illegal capacitor-code flag |

## Verification
The checker watches, on every cycle, that the range and relay enables are mutually exclusive, that the capacitor enable is always one-hot, that an empty range decode implies standby, that the illegal flag never falls, and that the comparator and clamp flags hold in every cycle without an internal publish pulse. Only the bench's scenarios show the actual values: which range and capacitor each code selects, that a strobe with the select high is ignored, that a compare sample stays hidden until the next strobe, the strict threshold comparisons at equality, and the mux source and high-impedance state of the measurement output.

// File: rtl/pmu_ctrl_pkg.sv
package pmu_ctrl_pkg;
  localparam int RANGE_BITS   = 3;
  localparam int CAP_BITS     = 2;
  localparam int N_INT_RANGES = 4;
  localparam int N_CAPS       = 3;
  localparam int EXT_LO_CODE  = 4;
  localparam int EXT_HI_CODE  = 5;

  typedef struct packed {
    logic [RANGE_BITS-1:0] range_code;
    logic [CAP_BITS-1:0]   cap_code;
    logic                  force_i;
    logic                  meas_i;
    logic                  cmp_i;
    logic                  stby;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RESET = '{
    range_code: '0,
    cap_code:   '0,
    force_i:    1'b0,
    meas_i:     1'b0,
    cmp_i:      1'b0,
    stby:       1'b1
  };
endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= RST_VAL;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pmu_cfg_regs.sv
module pmu_cfg_regs
  import pmu_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic stb_n_s,
  input  cfg_t cfg_in,
  input  logic clamp_hi_s,
  input  logic clamp_lo_s,
  output cfg_t cfg_q,
  output logic pub,
  output logic clamp_hi_q,
  output logic clamp_lo_q,
  output logic illegal_q
);
  logic stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev <= 1'b1;
    else        stb_prev <= stb_n_s;
  end

  // qualifying strobe: rising edge of the synchronized strobe with select low
  assign pub = stb_n_s && !stb_prev && !cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_RESET;
      clamp_hi_q <= 1'b0;
      clamp_lo_q <= 1'b0;
      illegal_q  <= 1'b0;
    end else if (pub) begin
      cfg_q      <= cfg_in;
      clamp_hi_q <= clamp_hi_s;
      clamp_lo_q <= clamp_lo_s;
      if (&cfg_in.cap_code) illegal_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pmu_decode.sv
module pmu_decode
  import pmu_ctrl_pkg::*;
(
  input  cfg_t                    cfg,
  output logic [N_INT_RANGES-1:0] range_en,
  output logic                    ext4_en,
  output logic                    ext5_en,
  output logic                    standby,
  output logic [N_CAPS-1:0]       cap_en
);
  for (genvar r = 0; r < N_INT_RANGES; r++) begin : g_range
    assign range_en[r] = (cfg.range_code == RANGE_BITS'(r));
  end

  assign ext4_en = (cfg.range_code == RANGE_BITS'(EXT_LO_CODE));
  assign ext5_en = (cfg.range_code == RANGE_BITS'(EXT_HI_CODE));

  // codes above the last external range alias to standby
  assign standby = cfg.stby || (cfg.range_code > RANGE_BITS'(EXT_HI_CODE));

  logic [CAP_BITS-1:0] cap_eff;
  assign cap_eff = (&cfg.cap_code) ? '0 : cfg.cap_code;

  for (genvar c = 0; c < N_CAPS; c++) begin : g_cap
    assign cap_en[c] = (cap_eff == CAP_BITS'(c));
  end
endmodule

// File: rtl/pmu_window_cmp.sv
module pmu_window_cmp #(
  parameter int MEAS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_clk_s,
  input  logic              pub,
  input  logic              use_i,
  input  logic [MEAS_W-1:0] v_code,
  input  logic [MEAS_W-1:0] i_code,
  input  logic [MEAS_W-1:0] thr_hi,
  input  logic [MEAS_W-1:0] thr_lo,
  output logic              flag_hi,
  output logic              flag_lo
);
  logic clk_prev, sample;
  logic pend_hi, pend_lo;
  logic signed [MEAS_W-1:0] sel_s, hi_s, lo_s;

  assign sel_s  = use_i ? $signed(i_code) : $signed(v_code);
  assign hi_s   = $signed(thr_hi);
  assign lo_s   = $signed(thr_lo);
  assign sample = cmp_clk_s && !clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      pend_hi  <= 1'b0;
      pend_lo  <= 1'b0;
      flag_hi  <= 1'b0;
      flag_lo  <= 1'b0;
    end else begin
      clk_prev <= cmp_clk_s;
      if (sample) begin
        pend_hi <= (sel_s > hi_s);
        pend_lo <= (sel_s < lo_s);
      end
      if (pub) begin
        flag_hi <= pend_hi;
        flag_lo <= pend_lo;
      end
    end
  end
endmodule

// File: rtl/pmu_ctrl_if.sv
module pmu_ctrl_if
  import pmu_ctrl_pkg::*;
#(
  parameter int MEAS_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    stb_n,
  input  logic                    cmp_clk,
  input  logic [RANGE_BITS-1:0]   range_code,
  input  logic [CAP_BITS-1:0]     cap_code,
  input  logic                    force_sel,
  input  logic                    meas_sel,
  input  logic                    cmp_sel,
  input  logic                    standby_req,
  input  logic                    clamp_hi_det,
  input  logic                    clamp_lo_det,
  input  logic                    meas_oe_n,
  input  logic [MEAS_W-1:0]       v_code,
  input  logic [MEAS_W-1:0]       i_code,
  input  logic [MEAS_W-1:0]       thr_hi,
  input  logic [MEAS_W-1:0]       thr_lo,
  output logic [N_INT_RANGES-1:0] range_en,
  output logic                    ext4_en,
  output logic                    ext5_en,
  output logic                    standby_out,
  output logic [N_CAPS-1:0]       cap_en,
  output logic                    force_current,
  output logic [MEAS_W-1:0]       meas_out,
  output logic                    cmp_hi,
  output logic                    cmp_lo,
  output logic                    clamp_hi_flag,
  output logic                    clamp_lo_flag,
  output logic                    cfg_illegal
);
  localparam int CTRL_W = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b110001;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  cfg_t cfg_raw, cfg_s, cfg_q;
  logic cs_n_s, stb_n_s, cmp_clk_s, clamp_hi_s, clamp_lo_s, oe_n_s;
  logic stb_pub;

  assign ctrl_raw = {cs_n, stb_n, cmp_clk, clamp_hi_det, clamp_lo_det, meas_oe_n};
  assign {cs_n_s, stb_n_s, cmp_clk_s, clamp_hi_s, clamp_lo_s, oe_n_s} = ctrl_s;

  assign cfg_raw = '{
    range_code: range_code,
    cap_code:   cap_code,
    force_i:    force_sel,
    meas_i:     meas_sel,
    cmp_i:      cmp_sel,
    stby:       standby_req
  };

  pmu_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  pmu_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL(CFG_RESET)) u_sync_cfg (
    .clk(clk), .rst_n(rst_n), .d(cfg_raw), .q(cfg_s)
  );

  pmu_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .stb_n_s(stb_n_s),
    .cfg_in(cfg_s), .clamp_hi_s(clamp_hi_s), .clamp_lo_s(clamp_lo_s),
    .cfg_q(cfg_q), .pub(stb_pub), .clamp_hi_q(clamp_hi_flag),
    .clamp_lo_q(clamp_lo_flag), .illegal_q(cfg_illegal)
  );

  pmu_decode u_dec (
    .cfg(cfg_q), .range_en(range_en), .ext4_en(ext4_en), .ext5_en(ext5_en),
    .standby(standby_out), .cap_en(cap_en)
  );

  pmu_window_cmp #(.MEAS_W(MEAS_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_clk_s(cmp_clk_s), .pub(stb_pub),
    .use_i(cfg_q.cmp_i), .v_code(v_code), .i_code(i_code),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .flag_hi(cmp_hi), .flag_lo(cmp_lo)
  );

  assign force_current = cfg_q.force_i;
  assign meas_out = oe_n_s ? {MEAS_W{1'bz}} : (cfg_q.meas_i ? i_code : v_code);
endmodule

// File: rtl/pmu_ctrl_if_chk.sv
module pmu_ctrl_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stb_pub,
  input logic [3:0] range_en,
  input logic       ext4_en,
  input logic       ext5_en,
  input logic       standby_out,
  input logic [2:0] cap_en,
  input logic       cmp_hi,
  input logic       cmp_lo,
  input logic       clamp_hi_flag,
  input logic       clamp_lo_flag,
  input logic       cfg_illegal
);
  assert_range_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(range_en));

  assert_ext_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext4_en || ext5_en) |-> (!(ext4_en && ext5_en) && range_en == 4'b0000));

  assert_empty_decode_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (range_en == 4'b0000 && !ext4_en && !ext5_en) |-> standby_out);

  assert_cap_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cap_en) == 1);

  assert_illegal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |=> cfg_illegal);

  assert_cmp_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_pub |=> $stable({cmp_hi, cmp_lo}));

  assert_clamp_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_pub |=> $stable({clamp_hi_flag, clamp_lo_flag}));
endmodule

bind pmu_ctrl_if pmu_ctrl_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stb_pub(stb_pub), .range_en(range_en),
  .ext4_en(ext4_en), .ext5_en(ext5_en), .standby_out(standby_out),
  .cap_en(cap_en), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
  .clamp_hi_flag(clamp_hi_flag), .clamp_lo_flag(clamp_lo_flag),
  .cfg_illegal(cfg_illegal)
);

// File: tb/pmu_ctrl_if_bench.sv
module pmu_ctrl_if_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, stb_n = 1'b1, cmp_clk = 1'b0;
  logic [2:0] range_code = '0;
  logic [1:0] cap_code = '0;
  logic force_sel = 0, meas_sel = 0, cmp_sel = 0, standby_req = 0;
  logic clamp_hi_det = 0, clamp_lo_det = 0, meas_oe_n = 0;
  logic [W-1:0] v_code = '0, i_code = '0, thr_hi = '0, thr_lo = '0;
  logic [3:0] range_en;
  logic ext4_en, ext5_en, standby_out, force_current;
  logic [2:0] cap_en;
  logic [W-1:0] meas_out;
  logic cmp_hi, cmp_lo, clamp_hi_flag, clamp_lo_flag, cfg_illegal;

  always #4 clk = ~clk;

  pmu_ctrl_if #(.MEAS_W(W)) u_pmu_ctrl_if (.*);

  typedef struct {
    string        tag;
    logic [3:0]   re;
    logic         e4, e5, sb, fc, hi, lo, ch, cl, ill;
    logic [2:0]   cap;
    logic [W-1:0] mo;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference state, from the requirements
  logic [2:0] m_code = 0;
  logic [1:0] m_cap = 0;
  logic m_fs = 0, m_ms = 0, m_cs = 0, m_sb = 1, m_ill = 0;
  logic m_ph = 0, m_pl = 0, m_hi = 0, m_lo = 0, m_ch = 0, m_cl = 0;

  task automatic push(string tag);
    exp_t e;
    e.tag = tag;
    e.re  = (m_code < 4) ? (4'b0001 << m_code) : 4'b0000;
    e.e4  = (m_code == 3'd4);
    e.e5  = (m_code == 3'd5);
    e.sb  = m_sb || (m_code >= 3'd6);
    e.cap = (m_cap == 2'd1) ? 3'b010 : (m_cap == 2'd2) ? 3'b100 : 3'b001;
    e.fc  = m_fs;
    e.hi  = m_hi; e.lo = m_lo; e.ch = m_ch; e.cl = m_cl; e.ill = m_ill;
    e.mo  = meas_oe_n ? {W{1'bz}} : (m_ms ? i_code : v_code);
    q.push_back(e);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic chk(string tag, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "R2 range_en", W'(range_en), W'(e.re));
        chk(e.tag, "R3 ext4_en", W'(ext4_en), W'(e.e4));
        chk(e.tag, "R3 ext5_en", W'(ext5_en), W'(e.e5));
        chk(e.tag, "R4 standby_out", W'(standby_out), W'(e.sb));
        chk(e.tag, "R5 cap_en", W'(cap_en), W'(e.cap));
        chk(e.tag, "R6 cfg_illegal", W'(cfg_illegal), W'(e.ill));
        chk(e.tag, "R8 cmp_hi", W'(cmp_hi), W'(e.hi));
        chk(e.tag, "R8 cmp_lo", W'(cmp_lo), W'(e.lo));
        chk(e.tag, "R9 meas_out", meas_out, e.mo);
        chk(e.tag, "R10 clamp_hi_flag", W'(clamp_hi_flag), W'(e.ch));
        chk(e.tag, "R10 clamp_lo_flag", W'(clamp_lo_flag), W'(e.cl));
        chk(e.tag, "R12 force_current", W'(force_current), W'(e.fc));
      end
    end
  end

  task automatic strobe(bit sel_low);
    cs_n = !sel_low;
    repeat (4) @(posedge clk);
    stb_n = 1'b0;
    repeat (4) @(posedge clk);
    stb_n = 1'b1;
    repeat (4) @(posedge clk);
    cs_n = 1'b1;
    repeat (4) @(posedge clk);
    if (sel_low) begin
      m_hi = m_ph; m_lo = m_pl;
      m_ch = clamp_hi_det; m_cl = clamp_lo_det;
      if (cap_code == 2'b11) m_ill = 1'b1;
      m_code = range_code; m_cap = cap_code; m_fs = force_sel;
      m_ms = meas_sel; m_cs = cmp_sel; m_sb = standby_req;
    end
  endtask

  task automatic compare_pulse();
    logic signed [W-1:0] s;
    cmp_clk = 1'b1;
    repeat (4) @(posedge clk);
    cmp_clk = 1'b0;
    repeat (4) @(posedge clk);
    s = m_cs ? $signed(i_code) : $signed(v_code);
    m_ph = (s > $signed(thr_hi));
    m_pl = (s < $signed(thr_lo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    v_code = 16'sd1200; i_code = -16'sd300;
    thr_hi = 16'sd500; thr_lo = -16'sd500;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    push("R11 reset");

    // R1: strobe with select high is ignored
    range_code = 3'b011; cap_code = 2'b10; force_sel = 1; meas_sel = 1;
    standby_req = 0; clamp_hi_det = 1;
    strobe(0);
    push("R1 ignored strobe");
    clamp_hi_det = 0;

    // R2/R5/R12: internal ranges with varied capacitor and selects
    for (int k = 0; k < 4; k++) begin
      range_code = 3'(k); cap_code = 2'(k % 3);
      force_sel = k[0]; meas_sel = k[1]; standby_req = 0;
      strobe(1);
      push("R2 internal range");
    end

    // R3: external ranges, R4: aliased standby codes and standby request
    range_code = 3'b100; strobe(1); push("R3 ext range 4");
    range_code = 3'b101; strobe(1); push("R3 ext range 5");
    range_code = 3'b110; strobe(1); push("R4 code 110");
    range_code = 3'b111; strobe(1); push("R4 code 111");
    range_code = 3'b010; standby_req = 1; strobe(1); push("R4 standby request");
    standby_req = 0;

    // R6: illegal capacitor code then a legal one
    cap_code = 2'b11; strobe(1); push("R6 illegal cap code");
    cap_code = 2'b01; strobe(1); push("R6 sticky after legal code");

    // R7/R8: voltage above upper threshold, hidden until strobe
    cmp_sel = 0; meas_sel = 0; strobe(1);
    compare_pulse(); push("R8 flags held before strobe");
    strobe(1); push("R7 voltage above window");

    // R7/R8: current below lower threshold
    cmp_sel = 1; strobe(1);
    i_code = -16'sd900;
    compare_pulse(); strobe(1); push("R7 current below window");

    // R8: equality at both thresholds sets neither flag
    i_code = 16'sd500; compare_pulse(); strobe(1); push("R8 equal upper");
    i_code = -16'sd500; compare_pulse(); strobe(1); push("R8 equal lower");

    // R8: a strobe with select high does not publish a new sample
    i_code = 16'sd2000; compare_pulse(); strobe(0); push("R8 unqualified strobe");
    strobe(1); push("R8 publish after qualified strobe");

    // R9: measure mux and high impedance
    meas_sel = 1; strobe(1); push("R9 current on meas_out");
    meas_oe_n = 1; repeat (4) @(posedge clk); push("R9 high impedance");
    meas_oe_n = 0; meas_sel = 0; v_code = -16'sd42; strobe(1);
    push("R9 voltage on meas_out");

    // R10: clamp flags follow detect inputs at strobe and hold afterwards
    clamp_hi_det = 1; clamp_lo_det = 0; strobe(1);
    clamp_hi_det = 0; clamp_lo_det = 1; repeat (4) @(posedge clk);
    push("R10 clamp held between strobes");
    strobe(1); push("R10 lower clamp published");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule